// File: doc/BRIEF.md
# Frame Template Playback Engine

This block stores up to eight short frame templates and replays any one of them on request as a stream of 16-bit words. Software loads the templates through a single write port carrying a 10-bit offset and an 18-bit entry in the same cycle. Only the upper half of the offset space (offsets 512 to 1023) reaches the template memory. The lower half belongs to a neighbouring function and never touches the templates.

Each template owns a fixed 64-word slot. Offset bits [8:6] pick the slot and bits [5:0] pick the word within it. An entry holds a 16-bit payload in bits [15:0]. Bit 16 marks the final word of the frame. Bit 17 asks the engine to send the live user value instead of the stored payload, so that one field, such as a sequence number or a timestamp, is patched while the frame is sent.

A start pulse with a template index begins playback. Words leave through a ready/valid handshake. A busy flag covers the whole playback, and further start pulses are ignored until the final word has been accepted.

Top module: `pkt_template_player`

## Requirements
- R1: A write with wrEn high and an offset of 512 or more stores wrEntry at template offset[8:6], word offset[5:0].
- R2: A write with an offset below 512 leaves every template unchanged.
- R3: startReq seen while idle starts template startSel. From the next cycle busy and outValid are high and word 0 of that template is presented.
- R4: For an entry with bit 17 clear, outData equals entry bits [15:0].
- R5: For an entry with bit 17 set, outData equals userWord as it is in that same cycle.
- R6: outLast is high for an entry with bit 16 set. Once that word is accepted (outValid and outReady both high), busy and outValid are low in the following cycle.
- R7: While outValid is high and outReady is low, the same word stays presented and the word index does not advance.
- R8: startReq while busy is ignored, and the current template plays on without any change.
- R9: If no entry in a slot has bit 16 set, word 63 is presented with outLast high and playback ends after it.
- R10: After reset, busy and outValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Buffer write strobe |
| wrOffset | input | 10 | Buffer offset of the write |
| wrEntry | input | 18 | Entry written: payload [15:0], last [16], substitute [17] |
| startReq | input | 1 | Start playback request |
| startSel | input | 3 | Template index to play |
| userWord | input | 16 | Value sent in place of substitute-flagged words |
| outReady | input | 1 | Downstream can accept a word |
| outValid | output | 1 | A template word is presented |
| outData | output | 16 | Presented word |
| outLast | output | 1 | Presented word is the last of the frame |
| busy | output | 1 | Playback in progress |

## Verification
A word pointer that goes wrong shows at outData in the very cycle after the bad step, as a payload from the wrong template or the wrong word. A dropped end condition shows as outValid staying high one cycle after the final handshake. Stalls are applied on alternate cycles, and userWord changes every cycle, so a pointer that moves without a handshake or a value latched at the wrong time appears at the next sampled word. A low-offset write aimed at a template word that carries the last flag would remove that flag, and the frame would then play past its expected length.

// File: rtl/pkt_tpl_pkg.sv
package pkt_tpl_pkg;
  typedef enum logic {
    SEQ_IDLE,
    SEQ_PLAY
  } seq_state_e;

  typedef struct packed {
    logic load;
    logic step;
  } seq_strobe_t;
endpackage

// File: rtl/tpl_sequencer.sv
module tpl_sequencer
  import pkt_tpl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        outReady,
  input  logic        wordLast,
  output seq_strobe_t strb,
  output logic        busy,
  output logic        playValid
);
  seq_state_e state, nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      SEQ_IDLE: if (startReq) begin
        strb.load = 1'b1;
        nextState = SEQ_PLAY;
      end
      SEQ_PLAY: if (outReady) begin
        if (wordLast) nextState = SEQ_IDLE;
        else          strb.step = 1'b1;
      end
      default: nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nextState;
  end

  assign busy      = (state == SEQ_PLAY);
  assign playValid = (state == SEQ_PLAY);

  p_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> busy);
  p_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (playValid && outReady && wordLast) |=> !busy);
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(outReady && wordLast)) |=> busy);
endmodule

// File: rtl/tpl_datapath.sv
module tpl_datapath
  import pkt_tpl_pkg::*;
#(
  parameter int OFFSET_W   = 10,
  parameter int DATA_W     = 16,
  parameter int TPL_CNT    = 8,
  parameter int SLOT_WORDS = 64,
  localparam int ENTRY_W   = DATA_W + 2,
  localparam int SLOT_AW   = $clog2(SLOT_WORDS),
  localparam int SEL_W     = $clog2(TPL_CNT),
  localparam int MEM_AW    = SLOT_AW + SEL_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [OFFSET_W-1:0] wrOffset,
  input  logic [ENTRY_W-1:0] wrEntry,
  input  logic [SEL_W-1:0]   startSel,
  input  logic [DATA_W-1:0]  userWord,
  input  seq_strobe_t        strb,
  output logic [DATA_W-1:0]  wordData,
  output logic               wordLast,
  output logic [MEM_AW-1:0]  curPtr
);
  localparam int MEM_DEPTH   = TPL_CNT * SLOT_WORDS;
  localparam int REGION_BASE = 1 << (OFFSET_W - 1);
  localparam int LAST_BIT    = DATA_W;
  localparam int SUB_BIT     = DATA_W + 1;

  logic [ENTRY_W-1:0]  tplMem [MEM_DEPTH];
  logic [OFFSET_W-1:0] relOffset;
  logic [MEM_AW-1:0]   wrAddr;
  logic                wrHit;
  logic [ENTRY_W-1:0]  curEntry;
  logic                slotEnd;

  // Template region is the upper half of the offset space only
  assign relOffset = wrOffset - OFFSET_W'(REGION_BASE);
  assign wrHit     = wrEn && (int'(wrOffset) >= REGION_BASE)
                     && (int'(relOffset) < MEM_DEPTH);
  assign wrAddr    = relOffset[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (wrHit) tplMem[wrAddr] <= wrEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          curPtr <= '0;
    else if (strb.load) curPtr <= {startSel, SLOT_AW'(0)};
    else if (strb.step) curPtr <= curPtr + 1'b1;
  end

  assign curEntry = tplMem[curPtr];
  assign slotEnd  = &curPtr[SLOT_AW-1:0];
  assign wordLast = curEntry[LAST_BIT] | slotEnd;
  assign wordData = curEntry[SUB_BIT] ? userWord : curEntry[DATA_W-1:0];
endmodule

// File: rtl/pkt_template_player.sv
module pkt_template_player
  import pkt_tpl_pkg::*;
#(
  parameter int OFFSET_W   = 10,
  parameter int DATA_W     = 16,
  parameter int TPL_CNT    = 8,
  parameter int SLOT_WORDS = 64,
  localparam int ENTRY_W   = DATA_W + 2,
  localparam int SEL_W     = $clog2(TPL_CNT),
  localparam int MEM_AW    = $clog2(SLOT_WORDS) + SEL_W
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [OFFSET_W-1:0] wrOffset,
  input  logic [ENTRY_W-1:0]  wrEntry,
  input  logic                startReq,
  input  logic [SEL_W-1:0]    startSel,
  input  logic [DATA_W-1:0]   userWord,
  input  logic                outReady,
  output logic                outValid,
  output logic [DATA_W-1:0]   outData,
  output logic                outLast,
  output logic                busy
);
  seq_strobe_t       strb;
  logic              wordLast;
  logic [MEM_AW-1:0] curPtr;

  tpl_sequencer u_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .outReady(outReady),
    .wordLast(wordLast), .strb(strb), .busy(busy), .playValid(outValid)
  );

  tpl_datapath #(
    .OFFSET_W(OFFSET_W), .DATA_W(DATA_W), .TPL_CNT(TPL_CNT), .SLOT_WORDS(SLOT_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOffset(wrOffset), .wrEntry(wrEntry),
    .startSel(startSel), .userWord(userWord), .strb(strb),
    .wordData(outData), .wordLast(wordLast), .curPtr(curPtr)
  );

  assign outLast = wordLast;

  p_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(curPtr)));
  p_advance_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outLast) |=> (curPtr == MEM_AW'($past(curPtr) + 1'b1)));
endmodule

// File: tb/pkt_template_player_tb.sv
module pkt_template_player_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [9:0] wrOffset = '0;
  logic [17:0] wrEntry = '0;
  logic startReq = 1'b0;
  logic [2:0] startSel = '0;
  logic [15:0] userWord = '0;
  logic outReady = 1'b0;
  logic outValid, outLast, busy;
  logic [15:0] outData;

  int checks = 0;
  int errors = 0;
  logic [17:0] model [512];

  always #4 clk = ~clk;

  pkt_template_player u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrOffset(wrOffset), .wrEntry(wrEntry),
    .startReq(startReq), .startSel(startSel), .userWord(userWord),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .outLast(outLast), .busy(busy)
  );

  // fields: [20:18] template, [17] stall, [16] start-while-busy, [15:0] user base
  localparam logic [20:0] VECS [6] = '{
    {3'd0, 1'b0, 1'b0, 16'h5A00},
    {3'd0, 1'b1, 1'b0, 16'hC300},
    {3'd1, 1'b0, 1'b0, 16'h0001},
    {3'd3, 1'b1, 1'b0, 16'h7700},
    {3'd7, 1'b0, 1'b0, 16'h9100},
    {3'd0, 1'b0, 1'b1, 16'h2200}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [9:0] off, input logic [17:0] ent);
    @(negedge clk);
    wrEn = 1'b1; wrOffset = off; wrEntry = ent;
    @(negedge clk);
    wrEn = 1'b0;
    if (off >= 10'd512) model[off - 10'd512] = ent; // R1 mapping: slot off[8:6], word off[5:0]
  endtask

  task automatic play(input int sel, input logic [15:0] user, input bit stall, input bit intr, output int len);
    int idx;
    int cyc;
    logic [17:0] e;
    logic [15:0] expData;
    bit expLast;
    idx = 0; cyc = 0; len = 0;
    @(negedge clk);
    startSel = 3'(sel); startReq = 1'b1; outReady = 1'b0;
    @(negedge clk);
    startReq = 1'b0;
    #1;
    chk(busy && outValid, "R3 start", {30'd0, busy, outValid}, 32'h3);
    while (idx < 64) begin
      outReady = stall ? cyc[0] : 1'b1;
      userWord = 16'(user + cyc);
      if (intr && idx == 2) begin startReq = 1'b1; startSel = 3'(sel + 1); end
      else startReq = 1'b0;
      #1;
      e = model[sel * 64 + idx];
      expData = e[17] ? userWord : e[15:0];
      expLast = e[16] || (idx == 63);
      chk(outValid === 1'b1, stall ? "R7 valid held" : "R3 valid", {31'd0, outValid}, 32'h1);
      chk(outData === expData, e[17] ? "R5 substitute" : (intr ? "R8 data" : "R4 payload"), {16'd0, outData}, {16'd0, expData});
      chk(outLast === expLast, (idx == 63 && !e[16]) ? "R9 slot end" : "R6 last flag", {31'd0, outLast}, {31'd0, expLast});
      if (outReady && expLast) begin
        len = idx + 1;
        break;
      end
      if (outReady) idx++;
      cyc++;
      @(negedge clk);
    end
    @(negedge clk);
    startReq = 1'b0; outReady = 1'b0;
    #1;
    chk(!busy && !outValid, "R6 end", {30'd0, busy, outValid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len;
    for (int i = 0; i < 512; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !outValid, "R10 reset", {30'd0, busy, outValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(!busy && !outValid, "R10 idle after reset", {30'd0, busy, outValid}, 32'h0);

    // R1: load templates 0, 1, 3, 7
    for (int i = 0; i < 6; i++)
      writeEntry(10'(512 + i), {(i == 2), (i == 5), 16'(16'h1000 + i)});
    writeEntry(10'(512 + 64), {2'b01, 16'hBEEF});
    for (int i = 0; i < 4; i++)
      writeEntry(10'(512 + 192 + i), {(i == 3), (i == 3), 16'(16'h3300 + i)});
    for (int i = 0; i < 64; i++)
      writeEntry(10'(512 + 448 + i), {(i == 10), 1'b0, 16'(i * 3)});

    // R2: low offsets aimed at template-0 words must not clear its last flag
    writeEntry(10'd5, 18'h0ABCD);
    writeEntry(10'd0, 18'h3FFFF);
    writeEntry(10'd511, 18'h0FFFF);

    foreach (VECS[v]) begin
      play(int'(VECS[v][20:18]), VECS[v][15:0], VECS[v][17], VECS[v][16], len);
    end

    play(0, 16'h0000, 1'b0, 1'b0, len);
    chk(len == 6, "R2 low writes ignored, length", 32'(len), 32'd6);
    play(7, 16'h0000, 1'b1, 1'b0, len);
    chk(len == 64, "R9 full-slot length", 32'(len), 32'd64);

    // R10: reset in the middle of playback
    @(negedge clk);
    startSel = 3'd7; startReq = 1'b1; outReady = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    #1;
    chk(!busy && !outValid, "R10 reset mid-playback", {30'd0, busy, outValid}, 32'h0);
    rstN = 1'b1;
    outReady = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule